// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Pending Latch

This block gathers a wide field of interrupt source lines into a handful of group interrupt outputs. Every group owns 32 source lines, an enable register and a status register, and drives one level output. When any line of a group goes from all-quiet to active, the lines that are both active and enabled form a select vector. The select vector is either delivered into the status register, which raises the group output, or is held in a hidden pending latch while the group is busy or masked.

Software reads a group's status register to find which sources fired and clears bits (write-one-to-clear) as each handler completes. Once the status register drains to zero, any latched pending sources are delivered automatically. Otherwise the group output drops. The enable register accumulates enables on every write that adds new bits. A write that adds no bit acts as a mask/unmask toggle against the previously written value. All access goes through a 32-bit word read/write port with one cycle of read latency.

Top module: `aic_top`

## Requirements
- R1: After synchronous reset every group output is low and every enable image, status register, scratch word, mask and pending latch reads back (or behaves) as zero.
- R2: Byte addresses are 12 bits. Group g has its enable image at g*0x100 and its status at g*0x100+4, and the group index is address bits [11:8]. Other word-aligned addresses below 0x808 are plain read/write storage. Addresses at or above 0x808 (including group indices of 9 and up) and addresses with bits [1:0] nonzero are ignored on write and read back as zero. Read data appears on the cycle after the read request.
- R3: A group evaluates its sources once per rising edge of the OR of its 32 lines, with select = lines AND accumulated enable. A zero select has no effect. Otherwise, with mask and status both zero, status is loaded with select and the group output is high after that edge.
- R4: A nonzero select that arrives while the group's status is nonzero is ORed into the pending latch, and status is left unchanged.
- R5: A nonzero select that arrives while the group's mask is nonzero goes to pending, even with status zero, and the output stays as it was.
- R6: An enable write ORs the data into the accumulated enable. If that adds bits, or if data and accumulated enable are both zero, only the image (read value) is replaced, and the mask is untouched.
- R7: An enable write that adds no bits computes change = image XOR data. If change AND data is nonzero, the changed bits are cleared from the mask; otherwise they are set in it. The image takes the data.
- R8: A status write of zero is ignored. Any other value clears the written bits.
- R9: A status write of all ones clears status and nothing else: pending stays latched and the output level is unchanged.
- R10: A status write (not all ones) that leaves status zero moves a nonzero pending latch into status and clears the latch, keeping the output high. With pending zero, the output goes low.
- R11: When a source event and a status write reach the same group in the same cycle, the status write is applied first and the event is judged against its result.
- R12: A group output is high whenever its status is nonzero. It falls only on a write to that group's status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for one 32-bit word |
| rd_en | input | 1 | Read request for one 32-bit word |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| src_i | input | 288 | Source lines; group g uses bits [g*32+31:g*32] |
| irq_o | output | 9 | One level interrupt output per group |

## Verification
Every register write and every source event takes effect on the clock edge that samples it, so the group output and status are due one edge later. Read data is due one edge after the read request. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the following falling edge. A source pulse is held for one edge and then dropped for one edge, so that each pulse is a single rising event. Hidden state (mask and pending latch) is checked through the status register and output after a later drain write. The same-cycle case applies an all-ones status write together with a new event, an order-sensitive pairing that yields a different status under the wrong order.

// File: rtl/aic_pkg.sv
package aic_pkg;
    // Width of one source group and of the register port
    parameter int SRC_W   = 32;
    parameter int DATA_W  = 32;
    // Byte address width and the bit where the group index starts
    parameter int ADDR_W  = 12;
    parameter int GRP_LSB = 8;
    localparam int WORD_W = ADDR_W - 2;
    localparam int SUB_W  = GRP_LSB - 2;
    localparam int GIDX_W = ADDR_W - GRP_LSB;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_ENA,
        KIND_STAT,
        KIND_SCR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e           kind;
        logic [GIDX_W-1:0]   grp;
        logic [WORD_W-1:0]   word;
    } reg_dec_t;

    typedef struct packed {
        logic [SRC_W-1:0] acc;   // accumulated enable
        logic [SRC_W-1:0] mask;  // masked sources
        logic [SRC_W-1:0] img;   // last written enable value
        logic [SRC_W-1:0] stat;  // delivered sources
        logic [SRC_W-1:0] pend;  // latched sources awaiting delivery
        logic             any;   // previous OR of the sources
        logic             irq;   // group output level
    } grp_state_t;

    // Number of words in the register window for a given group count
    function automatic int win_words(input int groups);
        return ((groups - 1) << (GRP_LSB - 2)) + 2;
    endfunction

    function automatic reg_dec_t decode(input logic [ADDR_W-1:0] a,
                                        input int groups);
        reg_dec_t d;
        logic [SUB_W-1:0] sub;
        d.word = a[ADDR_W-1:2];
        d.grp  = a[ADDR_W-1:GRP_LSB];
        sub    = a[GRP_LSB-1:2];
        if (a[1:0] != 2'b00 || int'(d.word) >= win_words(groups))
            d.kind = KIND_NONE;
        else if (int'(d.grp) < groups && sub == '0)
            d.kind = KIND_ENA;
        else if (int'(d.grp) < groups && sub == SUB_W'(1))
            d.kind = KIND_STAT;
        else
            d.kind = KIND_SCR;
        return d;
    endfunction
endpackage

// File: rtl/aic_group.sv
module aic_group
    import aic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_i,
    input  logic             ena_wr_i,
    input  logic             stat_wr_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] ena_img_o,
    output logic [SRC_W-1:0] stat_o,
    output logic             irq_o
);
    grp_state_t cur, nxt;
    logic [SRC_W-1:0] chg, sel;
    logic             rise;

    always_comb begin
        nxt  = cur;
        chg  = cur.img ^ wdata_i;
        nxt.any = |src_i;
        rise = nxt.any & ~cur.any;
        sel  = src_i & cur.acc;

        // enable register: accumulate, else mask/unmask toggle
        if (ena_wr_i) begin
            if (wdata_i == '0 && cur.acc == '0) begin
                nxt.img = '0;
            end else if ((cur.acc | wdata_i) != cur.acc) begin
                nxt.acc = cur.acc | wdata_i;
                nxt.img = wdata_i;
            end else begin
                if ((chg & wdata_i) != '0)
                    nxt.mask = cur.mask & ~chg;
                else
                    nxt.mask = cur.mask | chg;
                nxt.img = wdata_i;
            end
        end

        // status register: applied before a same-cycle event
        if (stat_wr_i && wdata_i != '0) begin
            nxt.stat = cur.stat & ~wdata_i;
            if (wdata_i != '1 && nxt.stat == '0) begin
                if (cur.pend != '0) begin
                    nxt.stat = cur.pend;
                    nxt.pend = '0;
                    nxt.irq  = 1'b1;
                end else begin
                    nxt.irq  = 1'b0;
                end
            end
        end

        // source event judged against the post-write status
        if (rise && sel != '0) begin
            if (cur.mask != '0 || nxt.stat != '0) begin
                nxt.pend = nxt.pend | sel;
            end else begin
                nxt.stat = sel;
                nxt.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign ena_img_o = cur.img;
    assign stat_o    = cur.stat;
    assign irq_o     = cur.irq;
endmodule

// File: rtl/aic_scratch.sv
module aic_scratch
    import aic_pkg::*;
#(
    parameter int WORDS = 514
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [WORD_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wr_i && int'(waddr_i) < WORDS) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (int'(raddr_i) < WORDS) rdata_o = mem[raddr_i];
    end
endmodule

// File: rtl/aic_top.sv
module aic_top
    import aic_pkg::*;
#(
    parameter int NUM_GROUPS = 9
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    input  logic [NUM_GROUPS*SRC_W-1:0] src_i,
    output logic [NUM_GROUPS-1:0]       irq_o
);
    localparam int WIN_WORDS = win_words(NUM_GROUPS);

    reg_dec_t dec;
    logic [NUM_GROUPS-1:0]       ena_wr, stat_wr;
    logic [NUM_GROUPS*SRC_W-1:0] ena_flat, stat_flat;
    logic [DATA_W-1:0]           scr_rd, rd_mux, rdata_q;
    logic                        scr_wr;

    assign dec    = decode(addr, NUM_GROUPS);
    assign scr_wr = wr_en && dec.kind == KIND_SCR;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign ena_wr[g]  = wr_en && dec.kind == KIND_ENA  && int'(dec.grp) == g;
        assign stat_wr[g] = wr_en && dec.kind == KIND_STAT && int'(dec.grp) == g;

        aic_group u_grp (
            .clk       (clk),
            .rst       (rst),
            .src_i     (src_i[g*SRC_W +: SRC_W]),
            .ena_wr_i  (ena_wr[g]),
            .stat_wr_i (stat_wr[g]),
            .wdata_i   (wdata),
            .ena_img_o (ena_flat[g*SRC_W +: SRC_W]),
            .stat_o    (stat_flat[g*SRC_W +: SRC_W]),
            .irq_o     (irq_o[g])
        );
    end

    aic_scratch #(.WORDS(WIN_WORDS)) u_scr (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (scr_wr),
        .waddr_i (dec.word),
        .wdata_i (wdata),
        .raddr_i (dec.word),
        .rdata_o (scr_rd)
    );

    always_comb begin
        rd_mux = '0;
        unique case (dec.kind)
            KIND_SCR: rd_mux = scr_rd;
            KIND_ENA, KIND_STAT: begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (int'(dec.grp) == g)
                        rd_mux = (dec.kind == KIND_ENA) ? ena_flat[g*SRC_W +: SRC_W]
                                                        : stat_flat[g*SRC_W +: SRC_W];
                end
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/aic_checker.sv
module aic_checker
    import aic_pkg::*;
#(
    parameter int NUM_GROUPS = 9
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic                        rd_en,
    input logic [ADDR_W-1:0]           addr,
    input logic [DATA_W-1:0]           rdata,
    input logic [NUM_GROUPS-1:0]       irq_o,
    input logic [NUM_GROUPS*SRC_W-1:0] stat_flat
);
    // R1
    reset_irq_low_chk: assert property (@(posedge clk) rst |=> irq_o == '0);

    // R2
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(4)) |=> rdata == $past(stat_flat[SRC_W-1:0]));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(g * 256 + 4);

        // R12
        stat_means_irq_chk: assert property (@(posedge clk) disable iff (rst)
            stat_flat[g*SRC_W +: SRC_W] != '0 |-> irq_o[g]);

        // R12
        irq_fall_on_write_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(irq_o[g]) |-> $past(wr_en && addr == STAT_A));

        // R4
        busy_stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (stat_flat[g*SRC_W +: SRC_W] != '0 && !(wr_en && addr == STAT_A))
            |=> $stable(stat_flat[g*SRC_W +: SRC_W]));
    end
endmodule

bind aic_top aic_checker #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .irq_o     (irq_o),
    .stat_flat (stat_flat)
);

// File: tb/sim_aic_top.sv
module sim_aic_top;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 9;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [11:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NG*32-1:0] src = '0;
    logic [NG-1:0]   irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aic_top #(.NUM_GROUPS(NG)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .src_i(src), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // one rising event: lines held for one edge, then dropped for one edge
    task automatic pulse(input int g, input logic [31:0] v);
        @(negedge clk); src[g*32 +: 32] = v;
        @(posedge clk);
        @(negedge clk); src[g*32 +: 32] = '0;
        @(posedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 irq after reset", 32'(irq), 32'h0);
        rd_chk("R1 enable image", 12'h000, 32'h0);
        rd_chk("R1 status", 12'h004, 32'h0);
        rd_chk("R1 scratch", 12'h010, 32'h0);
    endtask

    task automatic t_map();
        wr(12'h010, 32'hA5A5_A5A5);
        rd_chk("R2 scratch readback", 12'h010, 32'hA5A5_A5A5);
        wr(12'h808, 32'h1234_5678);
        rd_chk("R2 beyond window", 12'h808, 32'h0);
        wr(12'h900, 32'hFFFF_FFFF);
        rd_chk("R2 group 9 ignored", 12'h900, 32'h0);
        wr(12'h011, 32'h0000_0005);
        rd_chk("R2 misaligned write ignored", 12'h010, 32'hA5A5_A5A5);
        wr(12'h300, 32'h1);
        rd_chk("R2 group 3 enable", 12'h300, 32'h1);
        rd_chk("R2 group 3 status", 12'h304, 32'h0);
    endtask

    task automatic t_event();
        wr(12'h000, 32'hF0);
        rd_chk("R6 enable image", 12'h000, 32'hF0);
        pulse(0, 32'h105);
        @(negedge clk);
        check("R3 zero select irq", 32'(irq[0]), 32'h0);
        rd_chk("R3 zero select status", 12'h004, 32'h0);
        pulse(0, 32'h30);
        @(negedge clk);
        check("R3 irq raised", 32'(irq[0]), 32'h1);
        check("R3 other group quiet", 32'(irq[3]), 32'h0);
        rd_chk("R3 status loaded", 12'h004, 32'h30);
    endtask

    task automatic t_w1c_pending();
        wr(12'h004, 32'h0);
        rd_chk("R8 zero write ignored", 12'h004, 32'h30);
        wr(12'h004, 32'h10);
        rd_chk("R8 one bit cleared", 12'h004, 32'h20);
        check("R8 irq still high", 32'(irq[0]), 32'h1);
        pulse(0, 32'h80);
        rd_chk("R4 busy status unchanged", 12'h004, 32'h20);
        wr(12'h004, 32'h20);
        rd_chk("R10 pending delivered", 12'h004, 32'h80);
        check("R10 irq kept high", 32'(irq[0]), 32'h1);
        wr(12'h004, 32'h80);
        check("R10 irq dropped", 32'(irq[0]), 32'h0);
        rd_chk("R10 status empty", 12'h004, 32'h0);
    endtask

    task automatic t_same_cycle();
        pulse(0, 32'h20);
        rd_chk("R11 setup status", 12'h004, 32'h20);
        @(negedge clk);
        src[31:0] = 32'h40; wr_en = 1'b1; addr = 12'h004; wdata = 32'hFFFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        src[31:0] = '0; wr_en = 1'b0;
        @(posedge clk);
        rd_chk("R11 write before event", 12'h004, 32'h40);
        check("R11 irq high", 32'(irq[0]), 32'h1);
    endtask

    task automatic t_init();
        pulse(0, 32'h80);
        wr(12'h004, 32'hFFFF_FFFF);
        rd_chk("R9 init clears status", 12'h004, 32'h0);
        check("R9 irq unchanged", 32'(irq[0]), 32'h1);
        wr(12'h004, 32'h1);
        rd_chk("R9 pending kept through init", 12'h004, 32'h80);
        wr(12'h004, 32'h80);
        check("R9 drained", 32'(irq[0]), 32'h0);
    endtask

    task automatic t_mask();
        wr(12'h000, 32'h30);
        rd_chk("R6 image after mask write", 12'h000, 32'h30);
        pulse(0, 32'h10);
        @(negedge clk);
        check("R5 masked no irq", 32'(irq[0]), 32'h0);
        rd_chk("R5 masked status", 12'h004, 32'h0);
        wr(12'h000, 32'hF0);
        check("R7 unmask no delivery", 32'(irq[0]), 32'h0);
        wr(12'h004, 32'h1);
        rd_chk("R7 pending after unmask", 12'h004, 32'h10);
        wr(12'h004, 32'h10);
        pulse(0, 32'h20);
        rd_chk("R7 unmasked direct load", 12'h004, 32'h20);
        wr(12'h004, 32'h20);
        check("R7 cleared", 32'(irq[0]), 32'h0);
    endtask

    task automatic t_sticky();
        wr(12'h000, 32'h100);
        rd_chk("R6 image new bit", 12'h000, 32'h100);
        pulse(0, 32'h20);
        rd_chk("R6 sticky enable", 12'h004, 32'h20);
        wr(12'h004, 32'h20);
        wr(12'h800, 32'h0);
        rd_chk("R6 zero enable image", 12'h800, 32'h0);
        pulse(8, 32'hFFFF);
        @(negedge clk);
        check("R6 disabled group quiet", 32'(irq[8]), 32'h0);
        wr(12'h800, 32'h1);
        pulse(8, 32'h1);
        rd_chk("R3 group 8 status", 12'h804, 32'h1);
        check("R3 group 8 irq", 32'(irq), 32'h100);
        wr(12'h804, 32'h1);
        check("R10 group 8 dropped", 32'(irq[8]), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_map();
        t_event();
        t_w1c_pending();
        t_same_cycle();
        t_init();
        t_mask();
        t_sticky();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule